// File: doc/BRIEF.md
# Modem Control Register with Loopback Routing and Clock Output

This block is the host-facing control section of a low-speed modem that supports two signalling families: phase-shift keying at 1200 or 600 bit/s, and two frequency-shift keying standards. A host writes two 8-bit control registers over a small parallel bus with a 3-bit address. The block decodes the modulation choice, the test mode, the transmit-enable bit and the answer/originate bit from those registers. It then presents them to the modulator and demodulator, which are outside this block.

The same register contents steer the serial data. In normal operation and in analog loopback, host transmit data goes to the modulator and demodulated data goes to the host. Remote digital loopback echoes line data back to the line and holds the host receive line at mark. Local digital loopback returns host transmit data straight to the host receive line. A clock output pin echoes the crystal clock, or it carries a 50% duty clock at 16 times the data rate while a phase-shift keying mode is active. Writing the reset bit clears every register, and that bit is never stored.

Top module: `modem_ctl`

## Requirements
- R1: Register A is at address 0 and register B at address 1. A read returns the last value written, except that bit 3 of register B always reads 0. Other addresses read 0 and writes to them change nothing. Both registers read 0 after the hardware reset.
- R2: The modulation output `mod_o` is 0 when A[7]=0 and A[5]=0 (PSK 1200), 1 when A[7]=0 and A[5]=1 (PSK 600), 2 when A[7]=1 and A[4]=0 (FSK low-band standard), and 3 when A[7]=1 and A[4]=1 (FSK international standard). A[4] is ignored when A[7]=0, and A[5] is ignored when A[7]=1.
- R3: With B[1:0]=00 (normal) or 01 (analog loopback), `rxd_o` follows `demod_rxd_i` and `mod_txd_o` follows `txd_i`. `rx_tx_freq_o` is 1 only when B[1:0]=01.
- R4: With B[1:0]=10 (remote loopback), `mod_txd_o` follows `demod_rxd_i`, `rxd_o` is held at 1, and `txd_i` has no effect on either output.
- R5: With B[1:0]=11 (local loopback), `rxd_o` follows `txd_i` and the modulator keeps receiving `txd_i`.
- R6: A write of register B with bit 3 set clears both registers on that clock edge. Afterwards both registers read 0 and all outputs return to their reset values.
- R7: `clk_out_o` echoes the crystal clock `clk_i` when B[2]=0, or when A[7]=1 (FSK), even if B[2]=1.
- R8: With B[2]=1 and PSK 1200 selected, `clk_out_o` is high for 288 and low for 288 crystal cycles (crystal/576).
- R9: With B[2]=1 and PSK 600 selected, `clk_out_o` is high for 576 and low for 576 crystal cycles (crystal/1152).
- R10: When the rate changes while the divided clock runs, the divider restarts one crystal cycle later with the output low. The first rising edge follows a full new half-period after that restart.
- R11: `tx_en_o` equals A[1] and `ans_o` equals A[0] in every test mode, analog loopback included.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Crystal clock, also the block clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| we_i | input | 1 | Write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i |
| txd_i | input | 1 | Serial transmit data from host |
| rxd_o | output | 1 | Serial receive data to host |
| demod_rxd_i | input | 1 | Data from demodulator |
| mod_txd_o | output | 1 | Data to modulator |
| mod_o | output | 2 | Decoded modulation |
| tx_en_o | output | 1 | Transmit enable |
| ans_o | output | 1 | Answer/originate select |
| rx_tx_freq_o | output | 1 | Receiver uses transmit centre frequency |
| clk_out_o | output | 1 | Crystal echo or 16x data-rate clock |

## Verification
The hardest case to reach from the ports is a rate change in the middle of a divided-clock period. The stimulus first selects the 1200 bit/s rate with the divided clock enabled. It waits until the output is high, then rewrites register A to the 600 bit/s rate. It then counts the low cycles before the next rising edge, which must be a full new half-period with no leftover high pulse. The soft reset is reached by loading both registers with non-zero values and then writing the reset bit. Both registers must then read zero and the serial paths must return to normal.

// File: rtl/modem_ctl_pkg.sv
package modem_ctl_pkg;
  typedef enum logic [1:0] {
    MOD_PSK_FAST = 2'd0,
    MOD_PSK_SLOW = 2'd1,
    MOD_FSK_LOW  = 2'd2,
    MOD_FSK_INTL = 2'd3
  } mod_e;

  typedef enum logic [1:0] {
    TM_NORMAL = 2'd0,
    TM_ANALOG = 2'd1,
    TM_REMOTE = 2'd2,
    TM_LOCAL  = 2'd3
  } test_e;

  // bit positions inside register A
  localparam int A_FAMILY = 7;
  localparam int A_RATE   = 5;
  localparam int A_FSKSTD = 4;
  localparam int A_TXEN   = 1;
  localparam int A_ANS    = 0;
  // bit positions inside register B
  localparam int B_SRST   = 3;
  localparam int B_CKSEL  = 2;
endpackage

// File: rtl/modem_ctl_regs.sv
module modem_ctl_regs #(
  parameter int AW     = 3,
  parameter int DW     = 8,
  parameter int ADDR_A = 0,
  parameter int ADDR_B = 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] reg_a_o,
  output logic [DW-1:0] reg_b_o,
  output logic [DW-1:0] rdata_o
);
  import modem_ctl_pkg::*;

  localparam logic [AW-1:0] SEL_A = AW'(ADDR_A);
  localparam logic [AW-1:0] SEL_B = AW'(ADDR_B);

  logic [DW-1:0] reg_a_q, reg_a_d;
  logic [DW-1:0] reg_b_q, reg_b_d;
  logic          en_a, en_b, hit_a, hit_b, srst;

  assign hit_a = we_i && (addr_i == SEL_A);
  assign hit_b = we_i && (addr_i == SEL_B);
  assign srst  = hit_b && wdata_i[B_SRST];

  assign en_a = hit_a || srst;
  assign en_b = hit_b;

  always_comb begin
    reg_a_d = reg_a_q;
    reg_b_d = reg_b_q;
    if (srst) begin
      reg_a_d = '0;
      reg_b_d = '0;
    end else begin
      if (hit_a) reg_a_d = wdata_i;
      if (hit_b) reg_b_d = wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reg_a_q <= '0;
    end else if (en_a) begin
      reg_a_q <= reg_a_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reg_b_q <= '0;
    end else if (en_b) begin
      reg_b_q <= reg_b_d;
    end
  end

  always_comb begin
    if (addr_i == SEL_A)      rdata_o = reg_a_q;
    else if (addr_i == SEL_B) rdata_o = reg_b_q;
    else                      rdata_o = '0;
  end

  assign reg_a_o = reg_a_q;
  assign reg_b_o = reg_b_q;
endmodule

// File: rtl/modem_ctl_decode.sv
module modem_ctl_decode #(
  parameter int DW = 8
) (
  input  logic [DW-1:0]              reg_a_i,
  input  logic [DW-1:0]              reg_b_i,
  output modem_ctl_pkg::mod_e        mod_o,
  output modem_ctl_pkg::test_e       test_o,
  output logic                       tx_en_o,
  output logic                       ans_o,
  output logic                       rx_tx_freq_o,
  output logic                       div_run_o,
  output logic                       div_slow_o
);
  import modem_ctl_pkg::*;

  always_comb begin
    if (reg_a_i[A_FAMILY]) begin
      mod_o = reg_a_i[A_FSKSTD] ? MOD_FSK_INTL : MOD_FSK_LOW;
    end else begin
      mod_o = reg_a_i[A_RATE] ? MOD_PSK_SLOW : MOD_PSK_FAST;
    end
  end

  assign test_o       = test_e'(reg_b_i[1:0]);
  assign tx_en_o      = reg_a_i[A_TXEN];
  assign ans_o        = reg_a_i[A_ANS];
  assign rx_tx_freq_o = (test_o == TM_ANALOG);
  assign div_run_o    = reg_b_i[B_CKSEL] && !reg_a_i[A_FAMILY];
  assign div_slow_o   = reg_a_i[A_RATE];
endmodule

// File: rtl/modem_ctl_route.sv
module modem_ctl_route (
  input  modem_ctl_pkg::test_e test_i,
  input  logic                 txd_i,
  input  logic                 demod_rxd_i,
  output logic                 rxd_o,
  output logic                 mod_txd_o
);
  import modem_ctl_pkg::*;

  always_comb begin
    unique case (test_i)
      TM_REMOTE: begin
        rxd_o     = 1'b1;
        mod_txd_o = demod_rxd_i;
      end
      TM_LOCAL: begin
        rxd_o     = txd_i;
        mod_txd_o = txd_i;
      end
      default: begin
        rxd_o     = demod_rxd_i;
        mod_txd_o = txd_i;
      end
    endcase
  end
endmodule

// File: rtl/modem_ctl_clkdiv.sv
module modem_ctl_clkdiv #(
  parameter int DIV_FAST = 576,
  parameter int DIV_SLOW = 2 * DIV_FAST,
  parameter int CW       = $clog2(DIV_SLOW / 2)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic          slow_i,
  output logic          clk_out_o,
  output logic [CW-1:0] cnt_o
);
  localparam int HALF_FAST = DIV_FAST / 2;
  localparam int HALF_SLOW = DIV_SLOW / 2;
  localparam logic [CW-1:0] LAST_FAST = CW'(HALF_FAST - 1);
  localparam logic [CW-1:0] LAST_SLOW = CW'(HALF_SLOW - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          ph_q, ph_d;
  logic          slow_q, slow_d;
  logic [CW-1:0] last;

  assign last = slow_i ? LAST_SLOW : LAST_FAST;

  always_comb begin
    cnt_d  = cnt_q;
    ph_d   = ph_q;
    slow_d = slow_i;
    if (!run_i || (slow_q != slow_i)) begin
      cnt_d = '0;
      ph_d  = 1'b0;
    end else if (cnt_q == last) begin
      cnt_d = '0;
      ph_d  = ~ph_q;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      ph_q   <= 1'b0;
      slow_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      ph_q   <= ph_d;
      slow_q <= slow_d;
    end
  end

  assign clk_out_o = run_i ? ph_q : clk_i;
  assign cnt_o     = cnt_q;
endmodule

// File: rtl/modem_ctl.sv
module modem_ctl #(
  parameter int AW       = 3,
  parameter int DW       = 8,
  parameter int ADDR_A   = 0,
  parameter int ADDR_B   = 1,
  parameter int DIV_FAST = 576
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic          txd_i,
  output logic          rxd_o,
  input  logic          demod_rxd_i,
  output logic          mod_txd_o,
  output logic [1:0]    mod_o,
  output logic          tx_en_o,
  output logic          ans_o,
  output logic          rx_tx_freq_o,
  output logic          clk_out_o
);
  import modem_ctl_pkg::*;

  localparam int DIV_SLOW = 2 * DIV_FAST;
  localparam int CW       = $clog2(DIV_SLOW / 2);

  logic [DW-1:0] reg_a, reg_b;
  mod_e          mod_sel;
  test_e         test_sel;
  logic          div_run, div_slow;
  logic [CW-1:0] div_cnt;

  modem_ctl_regs #(
    .AW(AW), .DW(DW), .ADDR_A(ADDR_A), .ADDR_B(ADDR_B)
  ) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (we_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .reg_a_o (reg_a),
    .reg_b_o (reg_b),
    .rdata_o (rdata_o)
  );

  modem_ctl_decode #(.DW(DW)) u_dec (
    .reg_a_i      (reg_a),
    .reg_b_i      (reg_b),
    .mod_o        (mod_sel),
    .test_o       (test_sel),
    .tx_en_o      (tx_en_o),
    .ans_o        (ans_o),
    .rx_tx_freq_o (rx_tx_freq_o),
    .div_run_o    (div_run),
    .div_slow_o   (div_slow)
  );

  modem_ctl_route u_route (
    .test_i      (test_sel),
    .txd_i       (txd_i),
    .demod_rxd_i (demod_rxd_i),
    .rxd_o       (rxd_o),
    .mod_txd_o   (mod_txd_o)
  );

  modem_ctl_clkdiv #(
    .DIV_FAST(DIV_FAST), .DIV_SLOW(DIV_SLOW), .CW(CW)
  ) u_div (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (div_run),
    .slow_i    (div_slow),
    .clk_out_o (clk_out_o),
    .cnt_o     (div_cnt)
  );

  assign mod_o = mod_sel;
endmodule

// File: rtl/modem_ctl_chk.sv
module modem_ctl_chk #(
  parameter int AW     = 3,
  parameter int DW     = 8,
  parameter int ADDR_A = 0,
  parameter int ADDR_B = 1,
  parameter int CW     = 10,
  parameter int HALF_SLOW = 576
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          we_i,
  input logic [AW-1:0] addr_i,
  input logic [DW-1:0] wdata_i,
  input logic [DW-1:0] reg_a,
  input logic [DW-1:0] reg_b,
  input logic          txd_i,
  input logic          demod_rxd_i,
  input logic          rxd_o,
  input logic          mod_txd_o,
  input logic [CW-1:0] div_cnt
);
  AST_WRITE_A: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == AW'(ADDR_A)) |=> (reg_a == $past(wdata_i))); // R1
  AST_SRST_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == AW'(ADDR_B) && wdata_i[3]) |=> (reg_a == '0 && reg_b == '0)); // R6
  AST_SRST_NOT_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_b[3]); // R6
  AST_NORMAL_PATH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_b[1] |-> (rxd_o == demod_rxd_i && mod_txd_o == txd_i)); // R3
  AST_REMOTE_MARK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_b[1:0] == 2'b10) |-> (rxd_o && mod_txd_o == demod_rxd_i)); // R4
  AST_LOCAL_LOOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_b[1:0] == 2'b11) |-> (rxd_o == txd_i && mod_txd_o == txd_i)); // R5
  AST_DIV_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(reg_b[2] && !reg_a[7]) |=> (div_cnt == '0)); // R7
  AST_DIV_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_cnt < CW'(HALF_SLOW)); // R9
endmodule

bind modem_ctl modem_ctl_chk #(
  .AW(AW), .DW(DW), .ADDR_A(ADDR_A), .ADDR_B(ADDR_B),
  .CW(CW), .HALF_SLOW(DIV_SLOW / 2)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .we_i        (we_i),
  .addr_i      (addr_i),
  .wdata_i     (wdata_i),
  .reg_a       (reg_a),
  .reg_b       (reg_b),
  .txd_i       (txd_i),
  .demod_rxd_i (demod_rxd_i),
  .rxd_o       (rxd_o),
  .mod_txd_o   (mod_txd_o),
  .div_cnt     (div_cnt)
);

// File: tb/modem_ctl_test.sv
module modem_ctl_test;
  localparam int PERIOD = 10;
  localparam int NVEC   = 10;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       we_i = 1'b0;
  logic [2:0] addr_i = '0;
  logic [7:0] wdata_i = '0;
  logic       txd_i = 1'b0;
  logic       demod_rxd_i = 1'b0;
  logic [7:0] rdata_o;
  logic       rxd_o, mod_txd_o, tx_en_o, ans_o, rx_tx_freq_o, clk_out_o;
  logic [1:0] mod_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(PERIOD / 2) clk_i = ~clk_i;

  modem_ctl uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .txd_i(txd_i), .rxd_o(rxd_o),
    .demod_rxd_i(demod_rxd_i), .mod_txd_o(mod_txd_o), .mod_o(mod_o),
    .tx_en_o(tx_en_o), .ans_o(ans_o), .rx_tx_freq_o(rx_tx_freq_o),
    .clk_out_o(clk_out_o)
  );

  // {regA, regB, txd, demod, exp_mod, exp_rxd, exp_modtx, exp_rxtxfreq}
  localparam logic [22:0] VEC [NVEC] = '{
    {8'h10, 8'h00, 1'b1, 1'b0, 2'd0, 1'b0, 1'b1, 1'b0},
    {8'h30, 8'h00, 1'b0, 1'b1, 2'd1, 1'b1, 1'b0, 1'b0},
    {8'h80, 8'h01, 1'b1, 1'b0, 2'd2, 1'b0, 1'b1, 1'b1},
    {8'h92, 8'h01, 1'b0, 1'b1, 2'd3, 1'b1, 1'b0, 1'b1},
    {8'hB0, 8'h02, 1'b1, 1'b0, 2'd3, 1'b1, 1'b0, 1'b0},
    {8'hA1, 8'h02, 1'b0, 1'b1, 2'd2, 1'b1, 1'b1, 1'b0},
    {8'h12, 8'h03, 1'b1, 1'b0, 2'd0, 1'b1, 1'b1, 1'b0},
    {8'h32, 8'h03, 1'b0, 1'b1, 2'd1, 1'b0, 1'b0, 1'b0},
    {8'h00, 8'h02, 1'b1, 1'b1, 2'd0, 1'b1, 1'b1, 1'b0},
    {8'h03, 8'h00, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk_i);
    we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    we_i = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    addr_i = a;
    #1;
    d = rdata_o;
  endtask

  task automatic measure(output int hi, output int lo);
    do begin @(negedge clk_i); #1; end while (clk_out_o !== 1'b0);
    do begin @(negedge clk_i); #1; end while (clk_out_o !== 1'b1);
    hi = 0;
    while (clk_out_o === 1'b1) begin hi++; @(negedge clk_i); #1; end
    lo = 0;
    while (clk_out_o === 1'b0) begin lo++; @(negedge clk_i); #1; end
  endtask

  task automatic echo_check(input string req);
    @(posedge clk_i); #1;
    check(req, int'(clk_out_o), 1);
    @(negedge clk_i); #1;
    check(req, int'(clk_out_o), 0);
  endtask

  initial begin
    #(PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    int hi, lo;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 reset state
    rd(3'd0, r); check("R1 reset A", int'(r), 0);
    rd(3'd1, r); check("R1 reset B", int'(r), 0);
    echo_check("R7 reset echo");

    // vector table: decode, routing, readback
    for (int i = 0; i < NVEC; i++) begin
      logic [22:0] v;
      v = VEC[i];
      wr(3'd0, v[22:15]);
      wr(3'd1, v[14:7]);
      txd_i = v[6]; demod_rxd_i = v[5];
      #1;
      check("R2 mod", int'(mod_o), int'(v[4:3]));
      check("R3/R4/R5 rxd", int'(rxd_o), int'(v[2]));
      check("R3/R4/R5 modtx", int'(mod_txd_o), int'(v[1]));
      check("R3 rx_tx_freq", int'(rx_tx_freq_o), int'(v[0]));
      check("R11 tx_en", int'(tx_en_o), int'(v[16]));
      check("R11 ans", int'(ans_o), int'(v[15]));
      rd(3'd0, r); check("R1 readback A", int'(r), int'(v[22:15]));
      rd(3'd1, r); check("R1 readback B", int'(r), int'(v[14:7]));
    end

    // R4: txd ignored in remote loopback
    wr(3'd1, 8'h02);
    demod_rxd_i = 1'b0;
    txd_i = 1'b0; #1;
    check("R4 txd ignored rxd", int'(rxd_o), 1);
    check("R4 txd ignored modtx", int'(mod_txd_o), 0);
    txd_i = 1'b1; #1;
    check("R4 txd ignored rxd", int'(rxd_o), 1);
    check("R4 txd ignored modtx", int'(mod_txd_o), 0);

    // R1 unmapped address
    wr(3'd0, 8'h5A);
    wr(3'd5, 8'hFF);
    rd(3'd5, r); check("R1 unmapped read", int'(r), 0);
    rd(3'd0, r); check("R1 unmapped no effect A", int'(r), 8'h5A);
    rd(3'd1, r); check("R1 unmapped no effect B", int'(r), 8'h02);

    // R6 soft reset
    wr(3'd0, 8'h32);
    wr(3'd1, 8'h07);
    wr(3'd1, 8'h0F);
    rd(3'd0, r); check("R6 clears A", int'(r), 0);
    rd(3'd1, r); check("R6 clears B", int'(r), 0);
    txd_i = 1'b1; demod_rxd_i = 1'b0; #1;
    check("R6 routing normal", int'(rxd_o), 0);
    check("R6 tx_en", int'(tx_en_o), 0);
    echo_check("R6 echo after reset");

    // R7 FSK keeps echo even with clock select set
    wr(3'd0, 8'h80);
    wr(3'd1, 8'h04);
    repeat (3) @(negedge clk_i);
    echo_check("R7 FSK echo");

    // R8 PSK 1200 divided clock
    wr(3'd0, 8'h10);
    measure(hi, lo);
    check("R8 high", hi, 288);
    check("R8 low", lo, 288);

    // R10 rate change while output high
    do begin @(negedge clk_i); #1; end while (clk_out_o !== 1'b1);
    wr(3'd0, 8'h30);
    lo = 0;
    @(negedge clk_i); #1;
    while (clk_out_o === 1'b0) begin lo++; @(negedge clk_i); #1; end
    check("R10 restart low", lo, 576);

    // R9 PSK 600 divided clock
    measure(hi, lo);
    check("R9 high", hi, 576);
    check("R9 low", lo, 576);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule